// File: doc/BRIEF.md
# Character Input Port with Read-to-Acknowledge Interrupt

This block is the register front end of a character input device on a simple memory-mapped bus. Characters arrive one at a time on a valid strobe with an 8-bit code. The block latches each one and raises a ready flag. It requests an interrupt while a character waits and software has enabled interrupts.

A bus read of the character register hands the character over and drops the ready flag in the same step, so the service routine never writes an acknowledge. A status register reports the ready flag, a mirror of the request line, and a sticky overrun flag. When several devices share one interrupt line, a polling routine can find the source from the request mirror. A control register carries the interrupt enable. Clearing it silences the request line while the ready flag keeps its value.

Top module: `keyin_port`

## Requirements
- R1: After synchronous reset every register is zero. `irq` is low and `bus_rdata` is zero.
- R2: A cycle with `char_valid` high latches `char_data` and sets the ready flag. A read at offset 0 returns the character in bits 7:0, with all higher bits zero.
- R3: A read at offset 0 clears the ready flag in the next cycle, unless a new character arrives in that same cycle. No write is needed to acknowledge.
- R4: A read at offset 4 returns bit 0 = overrun, bit 1 = ready and bit 2 = interrupt request. All other bits are zero.
- R5: Offset 8 is the control register. Bit 1 is the interrupt enable, which can be both written and read. Every other bit of it reads as zero.
- R6: `irq` is high exactly when the ready flag and the enable bit are both set. A write of 0 to enable bit 1 lowers `irq` from the next cycle on.
- R7: A character that arrives while the ready flag is set, and is not consumed in that cycle, overwrites the held character and sets the overrun flag. A status read returns the flag and then clears it, unless a new overrun occurs in that same cycle.
- R8: Suppose a read at offset 0 and a new character occur in the same cycle. The read returns the old character, the ready flag stays set for the new one, and overrun is not set.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe. It holds its value until the next read.
- R10: Writes to offsets 0 and 4, or to any unmapped offset, change nothing. A read at an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | New character strobe |
| char_data | input | 8 | Character code |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the collisions within a single cycle. One is a character read that lands on the same edge as a new arrival. Another is a status read that lands on the edge where a fresh overrun is set. Both need the bus strobe and the arrival strobe to line up exactly. Directed sequences build each collision on purpose. After that, a long random run keeps arrivals dense (about one cycle in three) against random reads, so both collisions recur many times under the reference model.

// File: rtl/keyin_pkg.sv
package keyin_pkg;
    localparam int OFF_DATA = 0;
    localparam int OFF_STAT = 4;
    localparam int OFF_CTRL = 8;
    localparam int STAT_OVR_BIT = 0;
    localparam int STAT_RDY_BIT = 1;
    localparam int STAT_IRQ_BIT = 2;
    localparam int CTRL_EN_BIT  = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STAT,
        SEL_CTRL
    } regsel_e;

    typedef struct packed {
        logic overrun;
        logic ready;
    } flags_t;
endpackage

// File: rtl/keyin_capture.sv
module keyin_capture
    import keyin_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              consume,
    input  logic              status_rd,
    output logic [CHAR_W-1:0] char_q,
    output flags_t            flags_q
);
    logic lost;
    assign lost = char_valid && flags_q.ready && !consume;

    always_ff @(posedge clk) begin
        if (rst) begin
            char_q  <= '0;
            flags_q <= '0;
        end else begin
            if (char_valid) char_q <= char_data;
            if (char_valid)   flags_q.ready <= 1'b1;
            else if (consume) flags_q.ready <= 1'b0;
            if (lost)           flags_q.overrun <= 1'b1;
            else if (status_rd) flags_q.overrun <= 1'b0;
        end
    end

    AST_ARRIVAL_READY: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> flags_q.ready); // R2
    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (consume && !char_valid) |=> !flags_q.ready); // R3
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (char_valid && flags_q.ready && !consume) |=> flags_q.overrun); // R7
    AST_COLLIDE_NO_OVR: assert property (@(posedge clk) disable iff (rst)
        (char_valid && consume && !flags_q.overrun) |=> !flags_q.overrun); // R8
endmodule

// File: rtl/keyin_ctrl.sv
module keyin_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic enable_in,
    input  logic ready,
    output logic enable_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          enable_q <= 1'b0;
        else if (ctrl_wr) enable_q <= enable_in;
    end

    assign irq = ready && enable_q;

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (enable_q == $past(enable_in))); // R5
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(enable_q)); // R5
endmodule

// File: rtl/keyin_bus.sv
module keyin_bus
    import keyin_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CHAR_W-1:0] char_q,
    input  flags_t            flags,
    input  logic              enable,
    input  logic              irq,
    output logic              consume,
    output logic              status_rd,
    output logic              ctrl_wr,
    output logic              enable_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

    regsel_e sel;
    logic [DATA_W-1:0] rd_mux;
    logic unused_wdata;

    always_comb begin
        unique case (bus_addr)
            A_DATA:  sel = SEL_DATA;
            A_STAT:  sel = SEL_STAT;
            A_CTRL:  sel = SEL_CTRL;
            default: sel = SEL_NONE;
        endcase
    end

    assign consume      = bus_rd && (sel == SEL_DATA);
    assign status_rd    = bus_rd && (sel == SEL_STAT);
    assign ctrl_wr      = bus_wr && (sel == SEL_CTRL);
    assign enable_wdata = bus_wdata[CTRL_EN_BIT];
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_DATA: rd_mux = DATA_W'(char_q);
            SEL_STAT: begin
                rd_mux[STAT_OVR_BIT] = flags.overrun;
                rd_mux[STAT_RDY_BIT] = flags.ready;
                rd_mux[STAT_IRQ_BIT] = irq;
            end
            SEL_CTRL: rd_mux[CTRL_EN_BIT] = enable;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0)); // R10
    AST_DATA_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_DATA) |=> (bus_rdata[DATA_W-1:CHAR_W] == '0)); // R2
endmodule

// File: rtl/keyin_port.sv
module keyin_port
    import keyin_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CHAR_W-1:0] char_q;
    flags_t            flags;
    logic              consume, status_rd, ctrl_wr, enable_wdata, enable_q;

    keyin_capture #(.CHAR_W(CHAR_W)) u_capture (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .consume(consume), .status_rd(status_rd), .char_q(char_q), .flags_q(flags)
    );

    keyin_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .enable_in(enable_wdata),
        .ready(flags.ready), .enable_q(enable_q), .irq(irq)
    );

    keyin_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_bus (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .char_q(char_q), .flags(flags), .enable(enable_q),
        .irq(irq), .consume(consume), .status_rd(status_rd), .ctrl_wr(ctrl_wr),
        .enable_wdata(enable_wdata), .bus_rdata(bus_rdata)
    );

    AST_DISABLE_QUIETS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && !bus_wdata[CTRL_EN_BIT]) |=> !irq); // R6
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        irq |-> flags.ready); // R6
endmodule

// File: tb/keyin_port_bench.sv
module keyin_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    logic [7:0]  m_data;
    logic        m_rdy, m_ovr, m_en;
    logic [31:0] m_rdata;

    always #4 clk = ~clk;

    keyin_port u_keyin_port (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0:    return {24'h0, m_data};
            4'd4:    return {29'h0, m_rdy & m_en, m_rdy, m_ovr};
            4'd8:    return {30'h0, m_en, 1'b0};
            default: return 32'h0;
        endcase
    endfunction

    // one bus cycle: drive at negedge, model the edge, compare at next negedge
    task automatic tick(input logic cv, input logic [7:0] cd, input logic rd,
                        input logic wr, input logic [3:0] a, input logic [31:0] wd);
        logic consume, srd;
        char_valid = cv; char_data = cd; bus_rd = rd; bus_wr = wr;
        bus_addr = a; bus_wdata = wd;
        consume = rd && (a == 4'd0);
        srd     = rd && (a == 4'd4);
        @(posedge clk);
        if (rd) m_rdata = model_read(a);
        m_ovr  = (cv && m_rdy && !consume) ? 1'b1 : (srd ? 1'b0 : m_ovr);
        m_rdy  = cv ? 1'b1 : (consume ? 1'b0 : m_rdy);
        if (cv) m_data = cd;
        if (wr && a == 4'd8) m_en = wd[1];
        @(negedge clk);
        char_valid = 0; bus_rd = 0; bus_wr = 0;
        chk("R9 rdata", bus_rdata, m_rdata);
        chk("R6 irq", {31'h0, irq}, {31'h0, m_rdy & m_en});
    endtask

    task automatic rd(input logic [3:0] a); tick(0, 0, 1, 0, a, 0); endtask
    task automatic idle(); tick(0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_data = 0; m_rdy = 0; m_ovr = 0; m_en = 0; m_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 irq", {31'h0, irq}, 0);
        rd(4); chk("R1 status", bus_rdata, 0);
        rd(8); chk("R1 control", bus_rdata, 0);
        // R2 capture, R4 status layout
        tick(1, 8'h41, 0, 0, 0, 0);
        rd(4); chk("R4 status ready", bus_rdata, 32'h2);
        idle(); chk("R9 hold after read", bus_rdata, 32'h2);
        rd(0); chk("R2 data", bus_rdata, 32'h41);
        rd(4); chk("R3 ready cleared", bus_rdata, 32'h0);
        // R5 control
        tick(0, 0, 0, 1, 8, 32'hFFFF_FFFF);
        rd(8); chk("R5 enable reads", bus_rdata, 32'h2);
        chk("R6 no irq without char", {31'h0, irq}, 0);
        tick(1, 8'h0D, 0, 0, 0, 0);
        chk("R6 irq raised", {31'h0, irq}, 1);
        rd(4); chk("R4 status irq", bus_rdata, 32'h6);
        tick(0, 0, 0, 1, 8, 32'h0);
        chk("R6 irq dropped", {31'h0, irq}, 0);
        rd(4); chk("R6 ready kept", bus_rdata, 32'h2);
        // R7 overrun
        tick(1, 8'h55, 0, 0, 0, 0);
        rd(0); chk("R7 overwritten", bus_rdata, 32'h55);
        rd(4); chk("R7 overrun seen", bus_rdata, 32'h1);
        rd(4); chk("R7 overrun cleared", bus_rdata, 32'h0);
        // R7 status read colliding with a fresh overrun
        tick(1, 8'h11, 0, 0, 0, 0);
        tick(1, 8'h22, 1, 0, 4, 0); chk("R7 status before set", bus_rdata, 32'h2);
        rd(4); chk("R7 set wins over clear", bus_rdata, 32'h3);
        rd(0);
        // R8 read/arrival collision
        tick(1, 8'h31, 0, 0, 0, 0);
        tick(1, 8'h32, 1, 0, 0, 0); chk("R8 old char", bus_rdata, 32'h31);
        rd(4); chk("R8 ready kept no ovr", bus_rdata, 32'h2);
        rd(0); chk("R8 new char", bus_rdata, 32'h32);
        // R10 ignored writes
        tick(0, 0, 0, 1, 0, 32'hAB);
        tick(0, 0, 0, 1, 4, 32'h7);
        tick(0, 0, 0, 1, 12, 32'h2);
        rd(0); chk("R10 data unchanged", bus_rdata, 32'h32);
        rd(4); chk("R10 status unchanged", bus_rdata, 32'h0);
        rd(8); chk("R10 control unchanged", bus_rdata, 32'h0);
        rd(12); chk("R10 unmapped zero", bus_rdata, 32'h0);
        // random run
        for (int i = 0; i < 3000; i++) begin
            logic cv, r, w;
            logic [3:0] a;
            int op;
            cv = ($urandom_range(0, 2) == 0);
            op = $urandom_range(0, 3);
            r = (op <= 1);
            w = (op == 2);
            case ($urandom_range(0, 4))
                0: a = 4'd0; 1: a = 4'd4; 2: a = 4'd8; 3: a = 4'd0;
                default: a = 4'($urandom_range(0, 15));
            endcase
            tick(cv, 8'($urandom), r, w, a, $urandom);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule